// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a single-port synchronous SRAM whose shared data bus carries a new read or write on every clock, with no idle cycles between the two. Reads and writes use the same latency. The bus transfer for a command sampled at one enabled rising edge takes place at the second enabled rising edge after it. A controller can therefore alternate reads and writes freely, and the bus never needs a turnaround gap. The bidirectional bus is split into an input word, an output word and an output enable.

A load cycle takes an external address and a direction. Advance cycles then walk the two low address bits through a wrapping linear sequence and repeat the direction of the last load. Three chip enables qualify each load. If any of them is false, the cycle is a deselect, and the bus floats two edges later. A clock enable can freeze the whole machine, including the outputs. Writes are masked per 9-bit byte lane. A read issued one or two cycles after a write to the same word returns the new data. The address width is a parameter: it defaults to 8 so that elaboration stays small, and 17 gives the full 128K-word array.

Top module: `zbt_sram`

## Requirements
- R1: While rst_ni is low, and on every enabled edge until the first read reaches its data phase, data_oe_o is 0.
- R2: A load read (adv_i=0, all enables true, rd_nwr_i=1) presents the addressed word on data_o with data_oe_o=1 after the second enabled rising edge following the command edge.
- R3: A load write (rd_nwr_i=0) samples data_i at the second enabled rising edge after the command. During that data phase data_oe_o is 0.
- R4: Byte lane j occupies data bits [9j+8:9j]. It is written only when bw_ni[j] is 0, and bw_ni is sampled together with the command. Any mix of lanes may be written. A write with bw_ni=4'b1111 leaves the word unchanged.
- R5: With adv_i=1 after a load, the next address keeps the upper bits and sets the two low bits to the previous low bits plus 1, modulo 4. The operation repeats the last load's direction, and rd_nwr_i is ignored.
- R6: A cycle with adv_i=0 and any of ce1_ni=1, ce2_ni=1 or ce2_i=0 is a deselect. It writes nothing, and data_oe_o is 0 after the second enabled edge that follows it.
- R7: An advance cycle while no burst is active, such as after a deselect, is a no-operation. It writes nothing and leaves the bus undriven.
- R8: An edge with cen_ni=1 is ignored. data_o, data_oe_o, the pipeline, the burst state and the array all hold, and the command presented on that edge has no effect.
- R9: A read issued one or two cycles after a write to the same word returns the written lanes from that write and the stored contents in the unwritten lanes.
- R10: Reads and writes may be issued on consecutive cycles in any order with no idle cycle, and each one keeps its two-edge data latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cen_ni | input | 1 | Clock enable, active low; high blocks the edge |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| adv_i | input | 1 | 1 advances the burst, 0 loads an address or deselects |
| rd_nwr_i | input | 1 | 1 read, 0 write; used on load cycles only |
| bw_ni | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address for load cycles |
| data_i | input | 36 | Write data for the data phase |
| data_o | output | 36 | Read data |
| data_oe_o | output | 1 | High when data_o should drive the bus |

## Verification
The bench goes after read-after-write at distances of one and two cycles, including partial lane masks. A design that reads the array without forwarding returns stale bytes there, and one that forwards whole words corrupts the lanes that were not written. Bursts start at a low-bit value near the wrap point, and the direction pin is flipped during advances. A counter that carries into the upper bits, or that obeys rd_nwr_i on advance cycles, then touches the wrong words. Suspended edges are placed in the middle of a read and during a pending write with a command on the pins. A leaky clock enable shows up as a moved output or a changed word. Each of the three chip enables is used in turn before an orphan advance, which would otherwise drive the bus or write memory.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_cmd.sv
`timescale 1ns/1ps
// Command decode and burst address generation.
module zbt_cmd
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sel_i,
  input  logic              adv_i,
  input  logic              rd_nwr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              act_q;
  logic              rd_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] next_addr;

  // linear wrap: only the low BURST_W bits count
  always_comb begin
    next_addr = base_q;
    next_addr[BURST_W-1:0] = base_q[BURST_W-1:0] + BURST_W'(1);
  end

  always_comb begin
    op_o   = OP_NOP;
    addr_o = addr_i;
    if (!adv_i) begin
      if (sel_i) op_o = rd_nwr_i ? OP_RD : OP_WR;
    end else if (act_q) begin
      op_o   = rd_q ? OP_RD : OP_WR;
      addr_o = next_addr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      base_q <= '0;
    end else if (en_i) begin
      if (!adv_i) begin
        act_q <= sel_i;
        if (sel_i) begin
          rd_q   <= rd_nwr_i;
          base_q <= addr_i;
        end
      end else if (act_q) begin
        base_q <= next_addr;
      end
    end
  end
endmodule

// File: rtl/zbt_mem.sv
`timescale 1ns/1ps
// Lane-sliced array with registered read and same-edge write forwarding.
module zbt_mem #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic hit;
  assign hit = wr_en_i && (wr_addr_i == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic [LANE_W-1:0] wr_lane;

    assign wr_lane = wr_data_i[l*LANE_W +: LANE_W];

    always_ff @(posedge clk_i) begin
      if (en_i) begin
        if (wr_en_i && wr_be_i[l]) mem_q[wr_addr_i] <= wr_lane;
        if (rd_en_i) rd_q <= (hit && wr_be_i[l]) ? wr_lane : mem_q[rd_addr_i];
      end
    end

    assign rd_data_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              ce1_ni,
  input  logic              ce2_ni,
  input  logic              ce2_i,
  input  logic              adv_i,
  input  logic              rd_nwr_i,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              en, sel;
  op_e               op_c, op1_q, op2_q;
  logic [ADDR_W-1:0] addr_c, addr1_q, addr2_q;
  logic [LANES-1:0]  be1_q, be2_q;
  logic [DATA_W-1:0] rd_word, dout_q;
  logic              oe_q;

  assign en  = !cen_ni;
  assign sel = !ce1_ni && !ce2_ni && ce2_i;

  zbt_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .sel_i   (sel),
    .adv_i   (adv_i),
    .rd_nwr_i(rd_nwr_i),
    .addr_i  (addr_i),
    .op_o    (op_c),
    .addr_o  (addr_c)
  );

  // array access one edge after the command, data phase one edge later
  zbt_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i    (clk_i),
    .en_i     (en),
    .rd_en_i  (op1_q == OP_RD),
    .rd_addr_i(addr1_q),
    .wr_en_i  (op2_q == OP_WR),
    .wr_addr_i(addr2_q),
    .wr_be_i  (be2_q),
    .wr_data_i(data_i),
    .rd_data_o(rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op1_q   <= OP_NOP;
      op2_q   <= OP_NOP;
      addr1_q <= '0;
      addr2_q <= '0;
      be1_q   <= '0;
      be2_q   <= '0;
      dout_q  <= '0;
      oe_q    <= 1'b0;
    end else if (en) begin
      op1_q   <= op_c;
      addr1_q <= addr_c;
      be1_q   <= ~bw_ni;
      op2_q   <= op1_q;
      addr2_q <= addr1_q;
      be2_q   <= be1_q;
      oe_q    <= (op2_q == OP_RD);
      if (op2_q == OP_RD) dout_q <= rd_word;
    end
  end

  assign data_o    = dout_q;
  assign data_oe_o = oe_q;
endmodule

// File: rtl/zbt_sram_chk.sv
`timescale 1ns/1ps
module zbt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_ni,
  input logic              ce1_ni,
  input logic              ce2_ni,
  input logic              ce2_i,
  input logic              adv_i,
  input logic              rd_nwr_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o
);
  logic       en, sel, act_q;
  logic [1:0] rd_p, wr_p, ds_p, nop_p;

  assign en  = !cen_ni;
  assign sel = !ce1_ni && !ce2_ni && ce2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      rd_p  <= '0;
      wr_p  <= '0;
      ds_p  <= '0;
      nop_p <= '0;
    end else if (en) begin
      rd_p  <= {rd_p[0], !adv_i && sel && rd_nwr_i};
      wr_p  <= {wr_p[0], !adv_i && sel && !rd_nwr_i};
      ds_p  <= {ds_p[0], !adv_i && !sel};
      nop_p <= {nop_p[0], adv_i && !act_q};
      if (!adv_i) act_q <= sel;
    end
  end

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!data_oe_o);
  end

  assert_read_drives_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && rd_p[1]) |=> data_oe_o);

  assert_write_no_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && wr_p[1]) |=> !data_oe_o);

  assert_deselect_float_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && ds_p[1]) |=> !data_oe_o);

  assert_orphan_adv_float_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && nop_p[1]) |=> !data_oe_o);

  assert_suspend_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_ni |=> ($stable(data_oe_o) && $stable(data_o)));
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cen_ni   (cen_ni),
  .ce1_ni   (ce1_ni),
  .ce2_ni   (ce2_ni),
  .ce2_i    (ce2_i),
  .adv_i    (adv_i),
  .rd_nwr_i (rd_nwr_i),
  .data_o   (data_o),
  .data_oe_o(data_oe_o)
);

// File: tb/tb_zbt_sram.sv
`timescale 1ns/1ps
module tb_zbt_sram;
  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  // command kinds
  localparam int K_RD = 1, K_WR = 2, K_ADV = 3, K_DS1 = 4, K_DS2 = 5, K_DS3 = 6;

  logic clk = 1'b0, rst_ni = 1'b0, cen_ni = 1'b1;
  logic ce1_ni = 1'b1, ce2_ni = 1'b0, ce2_i = 1'b1, adv_i = 1'b0, rd_nwr_i = 1'b1;
  logic [LN-1:0] bw_ni = '1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;

  always #4 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cen_ni(cen_ni), .ce1_ni(ce1_ni), .ce2_ni(ce2_ni),
    .ce2_i(ce2_i), .adv_i(adv_i), .rd_nwr_i(rd_nwr_i), .bw_ni(bw_ni), .addr_i(addr_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] mdl [1<<AW];
  int            p_kind [2];
  logic [DW-1:0] p_data [2];
  string         p_tag  [2];
  bit            b_act = 1'b0, b_rd = 1'b0;
  logic [AW-1:0] b_addr = '0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                          input logic [LN-1:0] bwn);
    logic [DW-1:0] r = old_w;
    for (int l = 0; l < LN; l++) if (!bwn[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: present a command, drive pending write data, then check the data phase.
  task automatic cyc(input int kind, input logic [AW-1:0] a, input logic [LN-1:0] bwn,
                     input logic [DW-1:0] wd, input bit rnw, input bit hold, input string tag);
    int cur = 0;
    logic [AW-1:0] ca = a;
    logic [DW-1:0] pre_d = data_o;
    logic          pre_oe = data_oe_o;
    logic [DW-1:0] exp_d = wd;
    cen_ni   = hold;
    adv_i    = (kind == K_ADV);
    ce1_ni   = (kind == K_DS1);
    ce2_ni   = (kind == K_DS2);
    ce2_i    = (kind != K_DS3);
    rd_nwr_i = (kind == K_RD) ? 1'b1 : (kind == K_WR) ? 1'b0 : rnw;
    bw_ni    = bwn;
    addr_i   = a;
    data_i   = (p_kind[1] == K_WR) ? p_data[1] : wd;
    if (!hold) begin
      if (kind == K_RD || kind == K_WR) begin
        b_act = 1'b1; b_rd = (kind == K_RD); b_addr = a;
        cur = kind; ca = a;
      end else if (kind == K_ADV) begin
        if (b_act) begin
          ca = b_addr;
          ca[1:0] = b_addr[1:0] + 2'd1;
          b_addr = ca;
          cur = b_rd ? K_RD : K_WR;
        end
      end else begin
        b_act = 1'b0;
      end
      if (cur == K_WR) mdl[ca] = merge(mdl[ca], wd, bwn);
      if (cur == K_RD) exp_d = mdl[ca];
    end
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      check(data_oe_o == pre_oe, "R8", "oe held", DW'(data_oe_o), DW'(pre_oe));
      check(data_o == pre_d, "R8", "data held", data_o, pre_d);
    end else begin
      check(data_oe_o == (p_kind[1] == K_RD), p_tag[1], "oe", DW'(data_oe_o),
            DW'(p_kind[1] == K_RD));
      if (p_kind[1] == K_RD) check(data_o == p_data[1], p_tag[1], "read data", data_o, p_data[1]);
      p_kind[1] = p_kind[0]; p_data[1] = p_data[0]; p_tag[1] = p_tag[0];
      p_kind[0] = cur;       p_data[0] = exp_d;     p_tag[0] = tag;
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(K_RD, a, '1, '0, 1'b1, 1'b0, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] bwn, input logic [DW-1:0] d,
                    input string tag);
    cyc(K_WR, a, bwn, d, 1'b0, 1'b0, tag);
  endtask
  task automatic flush();
    cyc(K_DS1, '0, '1, '0, 1'b1, 1'b0, "R6");
    cyc(K_DS1, '0, '1, '0, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_reset();
    check(data_oe_o == 1'b0, "R1", "oe after reset", DW'(data_oe_o), '0);
    flush();  // drains the reset-state pipeline: oe stays low (R1)
  endtask

  task automatic t_mixed();  // R10 R2 R3
    wr(8'h10, 4'b0000, 36'h1_2345_6789, "R3");
    wr(8'h11, 4'b0000, 36'hA_BCDE_F012, "R3");
    rd(8'h10, "R2");
    rd(8'h11, "R10");
    wr(8'h12, 4'b0000, 36'h5_5AA5_AA55, "R10");
    rd(8'h12, "R9");
    wr(8'h13, 4'b0000, 36'h0_F0F0_F0F0, "R10");
    rd(8'h10, "R10");
    flush();
  endtask

  task automatic t_forward();  // R9 R4
    wr(8'h30, 4'b0000, 36'h1_1111_1111, "R9");
    wr(8'h30, 4'b1010, 36'hE_EEEE_EEEE, "R9");
    rd(8'h30, "R9");
    wr(8'h31, 4'b0000, 36'h3_3333_3333, "R9");
    wr(8'h31, 4'b0110, 36'hC_CCCC_CCCC, "R9");
    cyc(K_DS2, '0, '1, '0, 1'b1, 1'b0, "R6");
    rd(8'h31, "R9");
    flush();
  endtask

  task automatic t_bytes();  // R4
    wr(8'h40, 4'b0000, 36'h9_8765_4321, "R4");
    wr(8'h40, 4'b1111, 36'h0_0000_0000, "R4");
    flush();
    rd(8'h40, "R4");
    wr(8'h40, 4'b0101, 36'hF_FFFF_FFFF, "R4");
    flush();
    rd(8'h40, "R4");
    wr(8'h40, 4'b1110, 36'h0_0000_0000, "R4");
    flush();
    rd(8'h40, "R4");
    flush();
  endtask

  task automatic t_burst();  // R5
    wr(8'h2E, 4'b0000, 36'h0_0000_002E, "R5");
    cyc(K_ADV, 8'h77, 4'b0000, 36'h0_0000_002F, 1'b1, 1'b0, "R5");
    cyc(K_ADV, 8'h77, 4'b0000, 36'h0_0000_002C, 1'b1, 1'b0, "R5");
    cyc(K_ADV, 8'h77, 4'b0000, 36'h0_0000_002D, 1'b0, 1'b0, "R5");
    rd(8'h2F, "R5");
    cyc(K_ADV, 8'h00, '1, '0, 1'b0, 1'b0, "R5");
    cyc(K_ADV, 8'h00, '1, '0, 1'b0, 1'b0, "R5");
    cyc(K_ADV, 8'h00, '1, '0, 1'b0, 1'b0, "R5");
    cyc(K_ADV, 8'h00, '1, '0, 1'b0, 1'b0, "R5");
    rd(8'h30, "R5");  // neighbour outside the wrap window untouched
    flush();
  endtask

  task automatic t_deselect();  // R6 R7
    for (int v = K_DS1; v <= K_DS3; v++) begin
      rd(8'h12, "R2");
      cyc(v, 8'h12, 4'b0000, '0, 1'b0, 1'b0, "R6");
      cyc(K_ADV, 8'h12, 4'b0000, 36'h7_7777_7777, 1'b0, 1'b0, "R7");
      cyc(K_ADV, 8'h12, 4'b0000, 36'h6_6666_6666, 1'b0, 1'b0, "R7");
      rd(8'h12, "R7");
      flush();
    end
  endtask

  task automatic t_suspend();  // R8
    rd(8'h11, "R8");
    cyc(K_WR, 8'h11, 4'b0000, 36'hB_AD0B_AD0B, 1'b0, 1'b1, "R8");
    cyc(K_WR, 8'h11, 4'b0000, 36'hB_AD0B_AD0B, 1'b0, 1'b1, "R8");
    cyc(K_DS1, '0, '1, '0, 1'b1, 1'b0, "R8");
    cyc(K_DS1, '0, '1, '0, 1'b1, 1'b0, "R8");
    wr(8'h50, 4'b0000, 36'h2_4681_3579, "R8");
    rd(8'h11, "R8");
    cyc(K_RD, 8'h50, '1, '0, 1'b1, 1'b1, "R8");
    cyc(K_RD, 8'h50, '1, '0, 1'b1, 1'b1, "R8");
    rd(8'h50, "R8");
    flush();
    rd(8'h11, "R8");
    flush();
  endtask

  initial begin
    p_kind[0] = 0; p_kind[1] = 0;
    p_data[0] = '0; p_data[1] = '0;
    p_tag[0] = "R1"; p_tag[1] = "R1";
    for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_mixed();
    t_forward();
    t_bytes();
    t_burst();
    t_deselect();
    t_suspend();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule